// File: doc/BRIEF.md
# Lockable Watchdog Timer Controller

This block is a watchdog timer that sits on a small CPU register bus with two byte-wide addresses: a control register and a refresh register. After a system reset the watchdog is off. Software turns it on by setting the enable bit of the control register. From then on the enable cannot be withdrawn by software, and the timeout configuration is frozen. Only a system reset returns the block to the off state.

While running, a counter advances once per clock and expires after one of four power-of-two lengths chosen by a two-bit period code. Software keeps it alive by writing a two-byte key (0xA5 followed by 0x5A) to the refresh register, which restarts the count. On expiry the block sets a sticky cause flag. A routing bit then decides the response. By default a reset request is raised and held until the system reset arrives. With the routing bit set, a one-cycle non-maskable interrupt pulse is sent instead and the watchdog keeps counting. The cause flag is cleared only by reading the control register or by a power-on reset, so software can still see it after a reset that the watchdog caused.

The timeout state machine has four states. `EV_IDLE` is disabled. `EV_WATCH` is counting. `EV_NMI_PULSE` is the one-cycle interrupt. `EV_RST_HOLD` is the reset request, which is held.

Its transitions are:
- idle to watch on enable
- watch to pulse on expiry with routing bit 1
- watch to hold on expiry with routing bit 0
- pulse back to watch
- hold stays until reset

The refresh state machine has two states. `KS_WAIT_KEY1` moves to `KS_WAIT_KEY2` on a 0xA5 write. `KS_WAIT_KEY2` issues a restart on 0x5A. Any other refresh write in either state returns to `KS_WAIT_KEY1`.

Top module: `wdog_lock_ctrl`

## Requirements
- R1: After system and power-on reset, both timeout outputs are low and a control read returns 0x00. The control register layout is bit 7 enable, bit 3 cause flag, bit 2 routing bit, bits [1:0] period code, and the other bits read 0. Address 0 is control and address 1 is refresh.
- R2: Writing 1 to control bit 7 enables the watchdog. Later control writes with bit 7 at 0 leave it enabled.
- R3: Period code 00, 01, 10 and 11 select 2^SEL0_LOG2, 2^SEL1_LOG2, 2^SEL2_LOG2 and 2^SEL3_LOG2 cycles. The defaults are 27, 25, 22 and 18. An output rises exactly that many clock edges after the enabling write's edge.
- R4: The period code and routing bit take writes only while the watchdog is disabled. This includes the write that sets the enable bit. Once enabled, writes leave them unchanged.
- R5: With routing bit 0, a timeout raises `wdt_rst_req`. It stays high until a system reset, and `wdt_nmi` stays low.
- R6: With routing bit 1, a timeout gives a one-cycle `wdt_nmi` pulse and `wdt_rst_req` stays low. Counting continues, so the next pulse follows one period later.
- R7: A timeout sets the cause flag (bit 3). A control read returns it and clears it. A system reset leaves it set, and a power-on reset clears it.
- R8: Writing 0xA5 then 0x5A to the refresh address restarts the count from zero on the edge of the 0x5A write.
- R9: A refresh write that breaks the 0xA5, 0x5A order does not restart the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the counting clock |
| por_n | input | 1 | Active-low power-on reset, the only clear for the cause flag |
| rst_n | input | 1 | Active-low system reset for all other state |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a control read clears the cause flag |
| bus_addr | input | 1 | 0 selects control, 1 selects refresh |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 unless a control read |
| wdt_rst_req | output | 1 | Registered reset request, held until system reset |
| wdt_nmi | output | 1 | Registered one-cycle non-maskable interrupt pulse |

## Verification
On every cycle the assertions check the following:
- the enable never drops once set
- the configuration never moves while enabled
- the count never passes the selected terminal value
- an expiry always leaves the cause flag set
- the interrupt is never longer than one cycle
- the reset request, once raised, is held
- the two outputs are never high together
- both outputs stay quiet while the watchdog is disabled

Only the directed scenarios can show the behaviours that need a cycle count or a data sequence. These are the exact timeout length for each period code, that a correct key restarts the count, that a broken key does not, that the flag survives a system reset but not a power-on reset, and that a read clears it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic       ADDR_CTRL = 1'b0;
    localparam logic       ADDR_KICK = 1'b1;
    localparam logic [7:0] KICK_KEY1 = 8'hA5;
    localparam logic [7:0] KICK_KEY2 = 8'h5A;

    localparam int BIT_EN   = 7;
    localparam int BIT_FLAG = 3;
    localparam int BIT_NMI  = 2;

    typedef enum logic [1:0] {
        EV_IDLE,
        EV_WATCH,
        EV_NMI_PULSE,
        EV_RST_HOLD
    } ev_state_t;

    typedef enum logic {
        KS_WAIT_KEY1,
        KS_WAIT_KEY2
    } kick_state_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_n,
    input  logic       wr_ctrl,
    input  logic       rd_ctrl,
    input  logic       wr_en_bit,
    input  logic       wr_nmi_bit,
    input  logic [1:0] wr_period,
    input  logic       expire,
    output logic       en,
    output logic       nmi_sel,
    output logic [1:0] period,
    output logic       flag,
    output logic [7:0] rdata
);

    // Enable latch: set by software, cleared only by system reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else if (wr_ctrl && wr_en_bit) begin
            en <= 1'b1;
        end
    end

    // Configuration: writable only while disabled (pre-write value of en).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_sel <= 1'b0;
            period  <= 2'b00;
        end else if (wr_ctrl && !en) begin
            nmi_sel <= wr_nmi_bit;
            period  <= wr_period;
        end
    end

    // Cause flag lives in the power-on domain so a watchdog reset keeps it.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (rd_ctrl) begin
            flag <= 1'b0;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (rd_ctrl) begin
            rdata[BIT_EN]   = en;
            rdata[BIT_FLAG] = flag;
            rdata[BIT_NMI]  = nmi_sel;
            rdata[1:0]      = period;
        end
    end

    a_r2_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en)
        else $error("enable dropped without reset");

    a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ($stable(period) && $stable(nmi_sel)))
        else $error("configuration changed while enabled");

    a_r7_flag_on_timeout: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        expire |=> flag)
        else $error("timeout did not set cause flag");

endmodule

// File: rtl/wdog_kick_fsm.sv
module wdog_kick_fsm
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_kick,
    input  logic [7:0] wdata,
    output logic       restart
);

    kick_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (wr_kick) begin
            unique case (state_q)
                KS_WAIT_KEY1: state_d = (wdata == KICK_KEY1) ? KS_WAIT_KEY2 : KS_WAIT_KEY1;
                KS_WAIT_KEY2: state_d = KS_WAIT_KEY1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_WAIT_KEY1;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        restart = 1'b0;
        unique case (state_q)
            KS_WAIT_KEY1: restart = 1'b0;
            KS_WAIT_KEY2: restart = wr_kick && (wdata == KICK_KEY2);
        endcase
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int SEL0_LOG2 = 27,
    parameter int SEL1_LOG2 = 25,
    parameter int SEL2_LOG2 = 22,
    parameter int SEL3_LOG2 = 18,
    parameter int CNT_W     = 27
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] period,
    output logic       expire
);

    localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] TERM0 = CNT_W'((ONE << SEL0_LOG2) - ONE);
    localparam logic [CNT_W-1:0] TERM1 = CNT_W'((ONE << SEL1_LOG2) - ONE);
    localparam logic [CNT_W-1:0] TERM2 = CNT_W'((ONE << SEL2_LOG2) - ONE);
    localparam logic [CNT_W-1:0] TERM3 = CNT_W'((ONE << SEL3_LOG2) - ONE);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;
    logic             at_term;

    always_comb begin
        unique case (period)
            2'b00: term = TERM0;
            2'b01: term = TERM1;
            2'b10: term = TERM2;
            2'b11: term = TERM3;
        endcase
    end

    assign at_term = (cnt == term);
    assign expire  = run && !restart && at_term;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || restart || at_term) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r3_within_period: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= term))
        else $error("count passed the selected terminal value");

endmodule

// File: rtl/wdog_event_fsm.sv
module wdog_event_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic nmi_sel,
    input  logic expire,
    output logic hold,
    output logic rst_req,
    output logic nmi
);

    ev_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:      if (en) state_d = EV_WATCH;
            EV_WATCH:     if (expire) state_d = nmi_sel ? EV_NMI_PULSE : EV_RST_HOLD;
            EV_NMI_PULSE: state_d = EV_WATCH;
            EV_RST_HOLD:  state_d = EV_RST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs registered from the next state: they change only at rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            nmi     <= 1'b0;
        end else begin
            rst_req <= (state_d == EV_RST_HOLD);
            nmi     <= (state_d == EV_NMI_PULSE);
        end
    end

    assign hold = (state_q == EV_RST_HOLD);

    a_r6_nmi_single: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> !nmi)
        else $error("interrupt pulse longer than one cycle");

    a_r5_rst_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req)
        else $error("reset request released before system reset");

endmodule

// File: rtl/wdog_lock_ctrl.sv
module wdog_lock_ctrl
    import wdog_pkg::*;
#(
    parameter int SEL0_LOG2 = 27,
    parameter int SEL1_LOG2 = 25,
    parameter int SEL2_LOG2 = 22,
    parameter int SEL3_LOG2 = 18
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       wdt_rst_req,
    output logic       wdt_nmi
);

    localparam int CNT_W = max_of4(SEL0_LOG2, SEL1_LOG2, SEL2_LOG2, SEL3_LOG2);

    logic       wr_ctrl, rd_ctrl, wr_kick;
    logic       en, nmi_sel, flag, restart, expire, hold, run;
    logic [1:0] period;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign rd_ctrl = bus_rd && (bus_addr == ADDR_CTRL);
    assign wr_kick = bus_wr && (bus_addr == ADDR_KICK);
    assign run     = en && !hold;

    wdog_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_n      (por_n),
        .wr_ctrl    (wr_ctrl),
        .rd_ctrl    (rd_ctrl),
        .wr_en_bit  (bus_wdata[BIT_EN]),
        .wr_nmi_bit (bus_wdata[BIT_NMI]),
        .wr_period  (bus_wdata[1:0]),
        .expire     (expire),
        .en         (en),
        .nmi_sel    (nmi_sel),
        .period     (period),
        .flag       (flag),
        .rdata      (bus_rdata)
    );

    wdog_kick_fsm u_kick (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_kick (wr_kick),
        .wdata   (bus_wdata),
        .restart (restart)
    );

    wdog_counter #(
        .SEL0_LOG2 (SEL0_LOG2),
        .SEL1_LOG2 (SEL1_LOG2),
        .SEL2_LOG2 (SEL2_LOG2),
        .SEL3_LOG2 (SEL3_LOG2),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .period  (period),
        .expire  (expire)
    );

    wdog_event_fsm u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .nmi_sel (nmi_sel),
        .expire  (expire),
        .hold    (hold),
        .rst_req (wdt_rst_req),
        .nmi     (wdt_nmi)
    );

    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!wdt_rst_req && !wdt_nmi))
        else $error("timeout output while disabled");

    a_r5_outputs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wdt_rst_req && wdt_nmi))
        else $error("reset request and interrupt together");

endmodule

// File: tb/wdog_lock_ctrl_bench.sv
module wdog_lock_ctrl_bench;

    localparam int L0 = 10, L1 = 9, L2 = 7, L3 = 5;
    localparam int P0 = 1 << L0, P2 = 1 << L2, P3 = 1 << L3;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wdt_rst_req, wdt_nmi;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_lock_ctrl #(
        .SEL0_LOG2 (L0), .SEL1_LOG2 (L1), .SEL2_LOG2 (L2), .SEL3_LOG2 (L3)
    ) u_wdog_lock_ctrl (
        .clk (clk), .por_n (por_n), .rst_n (rst_n),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .wdt_rst_req (wdt_rst_req), .wdt_nmi (wdt_nmi)
    );

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp_v);
        end
    endtask

    task automatic sys_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic por_reset();
        @(negedge clk) begin por_n = 1'b0; rst_n = 1'b0; end
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk) begin bus_wr = 1'b1; bus_addr = a; bus_wdata = d; end
        @(negedge clk) bus_wr = 1'b0;
    endtask

    task automatic bus_read(output logic [7:0] d);
        @(negedge clk) begin bus_rd = 1'b1; bus_addr = 1'b0; end
        #1 d = bus_rdata;
        @(negedge clk) bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic enable(input logic [7:0] v);
        bus_write(1'b0, v);
        t0 = cyc;
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        por_reset();
        check("R1 rst_req", int'(wdt_rst_req), 0);
        check("R1 nmi", int'(wdt_nmi), 0);
        bus_read(d);
        check("R1 ctrl", int'(d), 'h00);
    endtask

    task automatic t_lock_freeze();
        logic [7:0] d;
        bus_write(1'b0, 8'h05);
        bus_read(d);
        check("R4 cfg while off", int'(d), 'h05);
        bus_write(1'b0, 8'h85);
        bus_read(d);
        check("R2 enable set", int'(d), 'h85);
        bus_write(1'b0, 8'h02);
        bus_read(d);
        check("R2 R4 write ignored", int'(d), 'h85);
        sys_reset();
        bus_read(d);
        check("R2 reset disables", int'(d), 'h00);
    endtask

    task automatic t_rst_mode();
        logic [7:0] d;
        enable(8'h83);
        wait_cyc(t0 + P3 - 1);
        check("R3 code11 early", int'(wdt_rst_req), 0);
        wait_cyc(t0 + P3);
        check("R3 R5 code11 rise", int'(wdt_rst_req), 1);
        check("R5 no nmi", int'(wdt_nmi), 0);
        repeat (6) @(negedge clk);
        check("R5 held", int'(wdt_rst_req), 1);
        bus_read(d);
        check("R7 flag read", int'(d), 'h8B);
        bus_read(d);
        check("R7 flag cleared", int'(d), 'h83);
        sys_reset();
        check("R5 released", int'(wdt_rst_req), 0);
    endtask

    task automatic t_flag_domains();
        logic [7:0] d;
        enable(8'h82);
        wait_cyc(t0 + P2 - 1);
        check("R3 code10 early", int'(wdt_rst_req), 0);
        wait_cyc(t0 + P2);
        check("R3 code10 rise", int'(wdt_rst_req), 1);
        sys_reset();
        bus_read(d);
        check("R7 survives system reset", int'(d), 'h08);
        bus_read(d);
        check("R7 cleared by read", int'(d), 'h00);
        enable(8'h83);
        wait_cyc(t0 + P3);
        check("R5 second timeout", int'(wdt_rst_req), 1);
        por_reset();
        bus_read(d);
        check("R7 cleared by power-on", int'(d), 'h00);
    endtask

    task automatic t_nmi_mode();
        logic [7:0] d;
        enable(8'h84);
        wait_cyc(t0 + P0 - 1);
        check("R3 code00 early", int'(wdt_nmi), 0);
        wait_cyc(t0 + P0);
        check("R3 R6 pulse", int'(wdt_nmi), 1);
        check("R6 no rst_req", int'(wdt_rst_req), 0);
        wait_cyc(t0 + P0 + 1);
        check("R6 single cycle", int'(wdt_nmi), 0);
        wait_cyc(t0 + 2 * P0 - 1);
        check("R6 gap", int'(wdt_nmi), 0);
        wait_cyc(t0 + 2 * P0);
        check("R6 second pulse", int'(wdt_nmi), 1);
        bus_read(d);
        check("R7 flag in nmi mode", int'(d), 'h8C);
        sys_reset();
    endtask

    task automatic t_refresh_ok();
        int tr;
        enable(8'h83);
        wait_cyc(t0 + 20);
        bus_write(1'b1, 8'hA5);
        bus_write(1'b1, 8'h5A);
        tr = cyc;
        wait_cyc(t0 + P3);
        check("R8 no timeout at old time", int'(wdt_rst_req), 0);
        wait_cyc(tr + P3 - 1);
        check("R8 restarted early", int'(wdt_rst_req), 0);
        wait_cyc(tr + P3);
        check("R8 restarted rise", int'(wdt_rst_req), 1);
        sys_reset();
    endtask

    task automatic t_refresh_bad();
        enable(8'h83);
        wait_cyc(t0 + 10);
        bus_write(1'b1, 8'hA5);
        bus_write(1'b1, 8'h33);
        bus_write(1'b1, 8'h5A);
        bus_write(1'b1, 8'h5A);
        bus_write(1'b1, 8'hA5);
        bus_write(1'b0, 8'h00);
        wait_cyc(t0 + P3 - 1);
        check("R9 early", int'(wdt_rst_req), 0);
        wait_cyc(t0 + P3);
        check("R9 original timeout", int'(wdt_rst_req), 1);
        sys_reset();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_lock_freeze();
        t_rst_mode();
        t_flag_domains();
        t_nmi_mode();
        t_refresh_ok();
        t_refresh_bad();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule